// File: doc/BRIEF.md
# Restoring Binary Divider

This block divides one unsigned integer by another over several clock cycles. A caller places a dividend and a divisor on the inputs and raises `start_i` for one cycle. The block then works one quotient bit at a time. It shifts its partial remainder and the dividend register left together. It makes a trial subtraction of the divisor. If that subtraction goes negative, it adds the divisor back and records a zero bit. Otherwise it keeps the difference and records a one bit.

When all quotient bits are settled, `done_o` pulses for one cycle. The quotient and remainder then stay on the outputs until the next accepted start. A zero divisor does not enter the loop. It returns at once with a flag raised. The `STEPS_PER_CYCLE` parameter sets how many iterations are chained in one clock. This trades latency against logic depth.

Top module: `longdiv_unit`

## Requirements
- R1: After synchronous reset, `busy_o`, `done_o` and `dz_o` are 0, and `quot_o` and `rem_o` are 0.
- R2: A start accepted while idle raises `busy_o` from the next cycle. With `WIDTH`/`STEPS_PER_CYCLE` = N, `done_o` is high for one cycle. That cycle follows the N-th rising edge after the start edge. `busy_o` is low from that cycle onward. For the defaults (16, 1), N is 16.
- R3: For a nonzero divisor, `quot_o` equals floor(dividend / divisor) and `rem_o` equals dividend mod divisor. Example: 274 / 13 gives quotient 21 and remainder 1. The internal partial remainder never holds a negative value between iterations.
- R4: For a nonzero divisor, the result satisfies quot × divisor + rem = dividend and rem < divisor.
- R5: `start_i` is ignored while `busy_o` is high. The running division keeps its operands and its timing, and no extra `done_o` pulse follows.
- R6: A zero divisor skips the loop. `done_o` and `dz_o` go high in the cycle right after the start edge. `quot_o` is all ones and `rem_o` equals the dividend.
- R7: `dz_o` stays high after a division by zero and is cleared by the next accepted start with a nonzero divisor, from the cycle after that start edge.
- R8: While idle with no start, `quot_o` and `rem_o` hold their values.
- R9: The boundary cases are exact:
  - a dividend below the divisor gives quotient 0 and remainder equal to the dividend;
  - the maximum dividend over 1 gives quotient equal to the dividend and remainder 0;
  - equal operands give quotient 1 and remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a division with the present operands (taken only when idle) |
| dividend_i | input | WIDTH | Unsigned dividend |
| divisor_i | input | WIDTH | Unsigned divisor |
| busy_o | output | 1 | Division loop in progress |
| done_o | output | 1 | One-cycle pulse: results valid |
| quot_o | output | WIDTH | Quotient |
| rem_o | output | WIDTH | Remainder |
| dz_o | output | 1 | Last result came from a zero divisor |

## Verification
The hardest situation to reach from the ports is a start request that arrives in the middle of a running division. This matters most when the ignored operands would themselves take the fast zero-divisor path. The stimulus therefore holds `start_i` high for several cycles right after an accepted start, with a zero divisor on the inputs. It then confirms three things: the original quotient appears, the latency is unchanged, and no second `done_o` pulse follows. The restore path on every bit is reached with divisors larger than the dividend and with the all-ones dividend over small divisors.

// File: rtl/longdiv_pkg.sv
package longdiv_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ld_state_e;

    typedef struct packed {
        logic load;      // accept operands, enter the loop
        logic zero_div;  // accept operands, divisor is zero
        logic iterate;   // perform STEPS_PER_CYCLE iterations this cycle
        logic finish;    // last group of iterations this cycle
    } ld_ctrl_t;

    function automatic int unsigned rounds_of(input int unsigned w, input int unsigned spc);
        return w / spc;
    endfunction

endpackage

// File: rtl/longdiv_step.sv
module longdiv_step #(
    parameter int unsigned W = 16
) (
    input  logic [W:0]   a_i,
    input  logic [W-1:0] q_i,
    input  logic [W-1:0] m_i,
    output logic [W:0]   a_o,
    output logic [W-1:0] q_o
);
    logic [W:0]   sh_a;
    logic [W-1:0] sh_q;
    logic [W:0]   trial;
    logic [W:0]   m_ext;

    always_comb begin
        m_ext = {1'b0, m_i};
        sh_a  = {a_i[W-1:0], q_i[W-1]};
        sh_q  = {q_i[W-2:0], 1'b0};
        trial = sh_a - m_ext;
        if (trial[W]) begin
            a_o = trial + m_ext;     // negative: put the divisor back
            q_o = sh_q;
        end else begin
            a_o = trial;
            q_o = sh_q | {{(W-1){1'b0}}, 1'b1};
        end
    end
endmodule

// File: rtl/longdiv_ctrl.sv
module longdiv_ctrl
    import longdiv_pkg::*;
#(
    parameter int unsigned W   = 16,
    parameter int unsigned SPC = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     divisor_zero_i,
    output ld_ctrl_t ctl_o,
    output logic     busy_o
);
    localparam int unsigned ROUNDS = rounds_of(W, SPC);
    localparam int unsigned CW     = $clog2(ROUNDS + 1);
    localparam logic [CW-1:0] LAST = CW'(ROUNDS - 1);

    ld_state_e     state;
    logic [CW-1:0] cnt;
    logic          accept;

    always_comb begin
        accept         = (state == ST_IDLE) && start_i;
        ctl_o          = '0;
        ctl_o.load     = accept && !divisor_zero_i;
        ctl_o.zero_div = accept && divisor_zero_i;
        ctl_o.iterate  = (state == ST_RUN);
        ctl_o.finish   = (state == ST_RUN) && (cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (ctl_o.load) state <= ST_RUN;
                end
                ST_RUN: begin
                    if (ctl_o.finish) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state == ST_RUN);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && cnt != LAST) |=> (state == ST_RUN));

    // R2
    idle_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (cnt == '0));
endmodule

// File: rtl/longdiv_unit.sv
module longdiv_unit
    import longdiv_pkg::*;
#(
    parameter int unsigned WIDTH           = 16,
    parameter int unsigned STEPS_PER_CYCLE = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] quot_o,
    output logic [WIDTH-1:0] rem_o,
    output logic             dz_o
);
    localparam int unsigned W   = WIDTH;
    localparam int unsigned SPC = STEPS_PER_CYCLE;

    initial begin
        if (W < 2 || SPC < 1 || (W % SPC) != 0)
            $error("longdiv_unit: WIDTH must be >= 2 and a multiple of STEPS_PER_CYCLE");
    end

    ld_ctrl_t     ctl;
    logic [W:0]   a_q;
    logic [W-1:0] q_q;
    logic [W-1:0] m_q;
    logic         done_q;
    logic         dz_q;

    logic [W:0]   a_ch [SPC+1];
    logic [W-1:0] q_ch [SPC+1];

    longdiv_ctrl #(.W(W), .SPC(SPC)) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .divisor_zero_i (divisor_i == '0),
        .ctl_o          (ctl),
        .busy_o         (busy_o)
    );

    assign a_ch[0] = a_q;
    assign q_ch[0] = q_q;

    for (genvar k = 0; k < SPC; k++) begin : g_step
        longdiv_step #(.W(W)) u_step (
            .a_i (a_ch[k]),
            .q_i (q_ch[k]),
            .m_i (m_q),
            .a_o (a_ch[k+1]),
            .q_o (q_ch[k+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            q_q    <= '0;
            m_q    <= '0;
            done_q <= 1'b0;
            dz_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (ctl.load) begin
                a_q  <= '0;
                q_q  <= dividend_i;
                m_q  <= divisor_i;
                dz_q <= 1'b0;
            end else if (ctl.zero_div) begin
                a_q    <= {1'b0, dividend_i};
                q_q    <= '1;
                m_q    <= '0;
                dz_q   <= 1'b1;
                done_q <= 1'b1;
            end else if (ctl.iterate) begin
                a_q <= a_ch[SPC];
                q_q <= q_ch[SPC];
                if (ctl.finish) done_q <= 1'b1;
            end
        end
    end

    assign done_o = done_q;
    assign dz_o   = dz_q;
    assign quot_o = q_q;
    assign rem_o  = a_q[W-1:0];

    // R3
    sign_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !a_q[W]);

    // R4
    rem_below_div_chk: assert property (@(posedge clk) disable iff (rst)
        (done_q && !dz_q) |-> (a_q < {1'b0, m_q}));

    // R2
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_o);

    // R6
    dz_result_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.zero_div |=> (done_q && dz_q && (q_q == '1)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !ctl.load && !ctl.zero_div) |=> ($stable(q_q) && $stable(a_q)));
endmodule

// File: tb/sim_longdiv_unit.sv
module sim_longdiv_unit;
    localparam int unsigned W   = 16;
    localparam int unsigned LAT = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [W-1:0] dividend_i = '0;
    logic [W-1:0] divisor_i = '0;
    logic         busy_o, done_o, dz_o;
    logic [W-1:0] quot_o, rem_o;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] exp_q  [$];
    logic [W-1:0] exp_r  [$];
    logic         exp_dz [$];
    logic [W-1:0] exp_dd [$];
    logic [W-1:0] exp_dv [$];

    always #4 clk = ~clk;

    longdiv_unit #(.WIDTH(W), .STEPS_PER_CYCLE(1)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .busy_o(busy_o), .done_o(done_o),
        .quot_o(quot_o), .rem_o(rem_o), .dz_o(dz_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard at every done pulse
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected done", 1, 0);
            end else begin
                automatic logic [W-1:0] eq  = exp_q.pop_front();
                automatic logic [W-1:0] er  = exp_r.pop_front();
                automatic logic         edz = exp_dz.pop_front();
                automatic logic [W-1:0] dd  = exp_dd.pop_front();
                automatic logic [W-1:0] dv  = exp_dv.pop_front();
                check(quot_o == eq, "R3 quotient", quot_o, eq);
                check(rem_o == er, "R3 remainder", rem_o, er);
                check(dz_o == edz, "R6 R7 dz flag", dz_o, edz);
                if (!edz) begin
                    check((64'(quot_o) * 64'(dv) + 64'(rem_o)) == 64'(dd),
                          "R4 q*d+r", 64'(quot_o) * 64'(dv) + 64'(rem_o), dd);
                    check(rem_o < dv, "R4 rem<div", rem_o, dv);
                end
            end
        end
    end

    task automatic push_exp(input logic [W-1:0] dd, input logic [W-1:0] dv);
        exp_dd.push_back(dd);
        exp_dv.push_back(dv);
        if (dv == 0) begin
            exp_q.push_back('1);
            exp_r.push_back(dd);
            exp_dz.push_back(1'b1);
        end else begin
            exp_q.push_back(dd / dv);
            exp_r.push_back(dd % dv);
            exp_dz.push_back(1'b0);
        end
    endtask

    // Driver: one division; hold_extra keeps start high while busy (R5)
    task automatic run_div(input logic [W-1:0] dd, input logic [W-1:0] dv, input int hold_extra);
        int n;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        start_i    = 1'b1;
        dividend_i = dd;
        divisor_i  = dv;
        push_exp(dd, dv);
        @(negedge clk);
        n = 1;
        if (dv != 0) begin
            check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
            check(dz_o == 1'b0, "R7 dz cleared", dz_o, 0);
        end
        if (hold_extra > 0) begin
            dividend_i = ~dd;
            divisor_i  = '0;   // would take the fast path if accepted
        end else begin
            start_i = 1'b0;
        end
        while (!done_o && n < 200) begin
            @(negedge clk);
            n++;
            if (n > hold_extra) start_i = 1'b0;
        end
        start_i = 1'b0;
        check((n - 1) == ((dv == 0) ? 0 : LAT), (dv == 0) ? "R6 latency" : "R2 latency",
              n - 1, (dv == 0) ? 0 : LAT);
        check(busy_o == 1'b0, "R2 busy low at done", busy_o, 0);
        @(negedge clk);
        check(done_o == 1'b0, "R2 done one cycle", done_o, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [W-1:0] hq, hr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(busy_o == 0 && done_o == 0 && dz_o == 0, "R1 reset flags", {busy_o, done_o, dz_o}, 0);
        check(quot_o == 0 && rem_o == 0, "R1 reset data", quot_o, 0);

        run_div(16'd274, 16'd13, 0);     // R3 21 r 1
        run_div(16'd100, 16'd7, 0);
        run_div(16'd5, 16'd9, 0);        // R9 dividend below divisor
        run_div(16'hFFFF, 16'd1, 0);     // R9 max / 1
        run_div(16'hBEEF, 16'hBEEF, 0);  // R9 equal
        run_div(16'd1234, 16'd0, 0);     // R6
        check(dz_o == 1'b1, "R7 dz stays set", dz_o, 1);
        run_div(16'd999, 16'd10, 0);     // R7 cleared by this start

        // R8 hold
        hq = quot_o; hr = rem_o;
        repeat (5) @(negedge clk);
        check(quot_o == hq && rem_o == hr, "R8 hold", quot_o, hq);

        // R5 start held while busy with a zero divisor on the inputs
        run_div(16'd50000, 16'd321, 4);
        repeat (25) @(negedge clk);
        check(exp_q.size() == 0, "R5 no extra result", exp_q.size(), 0);

        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] a, b;
            a = W'($urandom);
            b = W'($urandom) >> ($urandom % W);
            run_div(a, b, 0);
        end

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule